// File: doc/BRIEF.md
# Write-Update Snooping Coherence Controller

This block is the coherence controller for one small direct-mapped cache on a shared snooping bus. Each cache line holds a state, a tag and one data word. The controller takes read and write requests from its processor and sorts each one into a hit or a miss. When the protocol needs the bus, it requests it and issues a bus read, a bus update or a flush. Writes reach other caches by broadcasting the new word, not by invalidating their copies. A separate shared-dirty owner state means shared data is never written to memory by an update.

The controller also watches the transactions that other caches put on the bus. It raises the wired shared line when it holds a line that another cache is reading or updating. It hands over its dirty data when another cache reads that line, and it takes in broadcast words. The bus arbiter, memory and peer caches are outside the block.

Top module: `wu_snoop_ctrl`

## Requirements
- R1: After reset every line is empty. `bus_req_o` and `cpu_done_o` are low, and `cpu_ready_o` is high.
- R2: A read miss issues one bus read (command 1) of the request address. The line is filled from `bus_rdata_i` and the word is returned. The line becomes shared-clean if `bus_shared_i` was high during the read, and exclusive-clean if it was low. State codes are: empty 0, exclusive-clean 1, shared-clean 2, shared-modified 3, modified 4.
- R3: A read hit returns the stored word with no bus request. `cpu_done_o` pulses for exactly one cycle.
- R4: A write hit in exclusive-clean or modified writes the word locally and leaves the line in modified, with no bus traffic.
- R5: A write hit in shared-clean or shared-modified first wins the bus and issues an update (command 2) carrying the new word. Only then does it change the local copy. The line ends in shared-modified if `bus_shared_i` is high during the update, and in modified if it is low.
- R6: A write miss issues a bus read and then applies the write. If `bus_shared_i` was high during the read, a bus update of the new word follows and the line ends in shared-modified. If it was low, no update is issued and the line ends in modified.
- R7: On a miss, a victim line in modified or shared-modified is flushed (command 3, carrying the victim's address and word) before the bus read. A victim in exclusive-clean or shared-clean is dropped with no bus activity.
- R8: A snooped bus read that hits raises `snp_shared_o` in the same cycle. An exclusive-clean line moves to shared-clean. A modified or shared-modified line also raises `snp_flush_o` with its word on `snp_flush_data_o`, and ends in shared-modified.
- R9: A snooped bus update that hits raises `snp_shared_o`, overwrites the stored word with `snp_data_i`, and moves the line to shared-clean, including from shared-modified.
- R10: A snooped transaction whose address misses (tag mismatch or empty line) raises neither `snp_shared_o` nor `snp_flush_o`, and leaves the line unchanged.
- R11: `bus_cmd_o` is 0 except in a cycle where both `bus_req_o` and `bus_gnt_i` are high. While the grant is withheld, the request stays pending with the command at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_i | input | 1 | Processor request, taken when ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | AW | Word address of the request |
| cpu_wdata_i | input | DW | Write word |
| cpu_ready_o | output | 1 | Controller can take a request |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DW | Read word, or the written word on a write |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant; the transaction occupies that cycle |
| bus_cmd_o | output | 2 | 0 none, 1 read, 2 update, 3 flush |
| bus_addr_o | output | AW | Transaction address |
| bus_wdata_o | output | DW | Update or flush word |
| bus_rdata_i | input | DW | Fill word returned during a bus read |
| bus_shared_i | input | 1 | Wired shared line from the other caches |
| snp_cmd_i | input | 2 | Another cache's command, same encoding |
| snp_addr_i | input | AW | Snooped address |
| snp_data_i | input | DW | Snooped update word |
| snp_shared_o | output | 1 | This cache holds the snooped line |
| snp_flush_o | output | 1 | This cache supplies the snooped line |
| snp_flush_data_o | output | DW | Supplied word |

## Verification
A request is taken at one clock edge. A hit completes with `cpu_done_o` high after the second edge. A miss puts its bus read in the cycle after that second edge, and a victim flush or a follow-up update adds one granted cycle each before the done pulse. Snoop responses are combinational in the snooped cycle, and the line's new state shows only from the next edge, through later hits, updates or flushes. The bench therefore queues expected bus transactions and completion words in order. It compares each one in whatever cycle it appears, sampling a quarter period after the falling edge. Snoop outputs are checked within the cycle the bench drives them.

// File: rtl/wu_snoop_ctrl.sv
module wu_snoop_ctrl #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_ready_o,
  output logic          cpu_done_o,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic [1:0]    bus_cmd_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_shared_i,
  input  logic [1:0]    snp_cmd_i,
  input  logic [AW-1:0] snp_addr_i,
  input  logic [DW-1:0] snp_data_i,
  output logic          snp_shared_o,
  output logic          snp_flush_o,
  output logic [DW-1:0] snp_flush_data_o
);
  localparam int LINES = 1 << IW;
  localparam int TW = AW - IW;

  localparam logic [2:0] ST_INV = 3'd0, ST_EXC = 3'd1, ST_SHC = 3'd2, ST_SHM = 3'd3, ST_MOD = 3'd4;
  localparam logic [1:0] CMD_NONE = 2'd0, CMD_READ = 2'd1, CMD_UPD = 2'd2, CMD_FLUSH = 2'd3;

  typedef enum logic [2:0] {F_IDLE, F_LOOK, F_WB, F_RD, F_UPD} fsm_t;
  fsm_t fsm;

  logic [2:0]    st_q  [LINES];
  logic [TW-1:0] tag_q [LINES];
  logic [DW-1:0] dat_q [LINES];

  logic          rq_we;
  logic [AW-1:0] rq_addr;
  logic [DW-1:0] rq_wdata;
  logic          done_q;
  logic [DW-1:0] rdata_q;

  logic [IW-1:0] idx, s_idx;
  logic [TW-1:0] rtag, s_tag;
  logic          hit, s_hit, stall, won, victim_dirty;

  assign idx  = rq_addr[IW-1:0];
  assign rtag = rq_addr[AW-1:IW];
  assign hit  = (st_q[idx] != ST_INV) && (tag_q[idx] == rtag);
  assign victim_dirty = (st_q[idx] == ST_MOD) || (st_q[idx] == ST_SHM);

  assign s_idx = snp_addr_i[IW-1:0];
  assign s_tag = snp_addr_i[AW-1:IW];
  assign s_hit = (snp_cmd_i != CMD_NONE) && (st_q[s_idx] != ST_INV) && (tag_q[s_idx] == s_tag);
  assign stall = (snp_cmd_i != CMD_NONE) && (s_idx == idx);

  assign snp_shared_o     = s_hit && (snp_cmd_i == CMD_READ || snp_cmd_i == CMD_UPD);
  assign snp_flush_o      = s_hit && (snp_cmd_i == CMD_READ) &&
                            (st_q[s_idx] == ST_MOD || st_q[s_idx] == ST_SHM);
  assign snp_flush_data_o = dat_q[s_idx];

  assign cpu_ready_o = (fsm == F_IDLE);
  assign cpu_done_o  = done_q;
  assign cpu_rdata_o = rdata_q;

  assign bus_req_o   = (fsm == F_WB) || (fsm == F_RD) || (fsm == F_UPD);
  assign won         = bus_req_o && bus_gnt_i;
  assign bus_cmd_o   = !won ? CMD_NONE :
                       (fsm == F_WB) ? CMD_FLUSH :
                       (fsm == F_RD) ? CMD_READ : CMD_UPD;
  assign bus_addr_o  = (fsm == F_WB) ? {tag_q[idx], idx} : rq_addr;
  assign bus_wdata_o = (fsm == F_WB) ? dat_q[idx] : rq_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm      <= F_IDLE;
      done_q   <= 1'b0;
      rdata_q  <= '0;
      rq_we    <= 1'b0;
      rq_addr  <= '0;
      rq_wdata <= '0;
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_INV;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      done_q <= 1'b0;

      if (s_hit) begin
        if (snp_cmd_i == CMD_READ) begin
          if (st_q[s_idx] == ST_EXC) st_q[s_idx] <= ST_SHC;
          if (st_q[s_idx] == ST_MOD) st_q[s_idx] <= ST_SHM;
        end else if (snp_cmd_i == CMD_UPD) begin
          dat_q[s_idx] <= snp_data_i;
          st_q[s_idx]  <= ST_SHC;
        end
      end

      case (fsm)
        F_IDLE: if (cpu_req_i) begin
          rq_we    <= cpu_we_i;
          rq_addr  <= cpu_addr_i;
          rq_wdata <= cpu_wdata_i;
          fsm      <= F_LOOK;
        end
        F_LOOK: if (!stall) begin
          if (hit && !rq_we) begin
            rdata_q <= dat_q[idx];
            done_q  <= 1'b1;
            fsm     <= F_IDLE;
          end else if (hit && (st_q[idx] == ST_EXC || st_q[idx] == ST_MOD)) begin
            dat_q[idx] <= rq_wdata;
            st_q[idx]  <= ST_MOD;
            rdata_q    <= rq_wdata;
            done_q     <= 1'b1;
            fsm        <= F_IDLE;
          end else if (hit) begin
            fsm <= F_UPD;
          end else begin
            fsm <= victim_dirty ? F_WB : F_RD;
          end
        end
        F_WB: if (won) begin
          st_q[idx] <= ST_INV;
          fsm       <= F_RD;
        end
        F_RD: if (won) begin
          tag_q[idx] <= rtag;
          if (!rq_we) begin
            dat_q[idx] <= bus_rdata_i;
            st_q[idx]  <= bus_shared_i ? ST_SHC : ST_EXC;
            rdata_q    <= bus_rdata_i;
            done_q     <= 1'b1;
            fsm        <= F_IDLE;
          end else if (bus_shared_i) begin
            dat_q[idx] <= bus_rdata_i;
            st_q[idx]  <= ST_SHC;
            fsm        <= F_UPD;
          end else begin
            dat_q[idx] <= rq_wdata;
            st_q[idx]  <= ST_MOD;
            rdata_q    <= rq_wdata;
            done_q     <= 1'b1;
            fsm        <= F_IDLE;
          end
        end
        F_UPD: if (won) begin
          dat_q[idx] <= rq_wdata;
          st_q[idx]  <= bus_shared_i ? ST_SHM : ST_MOD;
          rdata_q    <= rq_wdata;
          done_q     <= 1'b1;
          fsm        <= F_IDLE;
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end

  assert_cmd_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_o != CMD_NONE) |-> (bus_req_o && bus_gnt_i));

  assert_flush_implies_shared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush_o |-> snp_shared_o);

  assert_done_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done_o |=> !cpu_done_o);

  assert_update_then_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_o == CMD_UPD) |=> cpu_done_o);

  assert_flush_then_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_o == CMD_FLUSH) |=> (bus_req_o && fsm == F_RD));

  assert_private_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_o == CMD_READ && !rq_we && !bus_shared_i) |=> (st_q[idx] == ST_EXC));

  assert_update_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hit && snp_cmd_i == CMD_UPD && fsm != F_UPD) |=> (st_q[$past(s_idx)] == ST_SHC));
endmodule

// File: tb/wu_snoop_ctrl_tb.sv
module wu_snoop_ctrl_tb_top;
  localparam int AW = 8, DW = 16, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cpu_req_i = 0, cpu_we_i = 0;
  logic [AW-1:0] cpu_addr_i = '0;
  logic [DW-1:0] cpu_wdata_i = '0;
  logic          cpu_ready_o, cpu_done_o;
  logic [DW-1:0] cpu_rdata_o;
  logic          bus_req_o, bus_gnt_i, bus_shared_i;
  logic [1:0]    bus_cmd_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_wdata_o, bus_rdata_i;
  logic [1:0]    snp_cmd_i = 0;
  logic [AW-1:0] snp_addr_i = '0;
  logic [DW-1:0] snp_data_i = '0;
  logic          snp_shared_o, snp_flush_o;
  logic [DW-1:0] snp_flush_data_o;

  logic          gnt_en = 1'b1, peer_share = 1'b0;
  logic [DW-1:0] mem [256];

  assign bus_gnt_i    = bus_req_o && gnt_en;
  assign bus_shared_i = bus_gnt_i && peer_share;
  assign bus_rdata_i  = mem[bus_addr_o];

  wu_snoop_ctrl #(.AW(AW), .DW(DW), .IW(IW)) dut_i (.*);

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  logic [27:0] exp_bus [$];
  string       bus_tag [$];
  logic [DW-1:0] exp_cpu [$];
  string       cpu_tag [$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_bus(input logic [1:0] cmd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit cmp_data, input string req);
    exp_bus.push_back({cmp_data, 1'b0, cmd, a, d});
    bus_tag.push_back(req);
  endtask

  always @(negedge clk) begin
    #5;
    if (rst_n && !finished) begin
      if (bus_cmd_o != 2'd0) begin
        if (exp_bus.size() == 0) begin
          check(0, "unexpected bus transaction", {22'd0, bus_cmd_o, bus_addr_o}, 0);
        end else begin
          logic [27:0] e;
          string t;
          e = exp_bus.pop_front();
          t = bus_tag.pop_front();
          check(bus_cmd_o == e[25:24] && bus_addr_o == e[23:16] && (!e[27] || bus_wdata_o == e[15:0]),
                t, {6'd0, bus_cmd_o, bus_addr_o, bus_wdata_o}, {6'd0, e[25:0]});
        end
        if (bus_cmd_o == 2'd3) mem[bus_addr_o] = bus_wdata_o;
      end
      if (cpu_done_o) begin
        if (exp_cpu.size() == 0) begin
          check(0, "unexpected completion", {16'd0, cpu_rdata_o}, 0);
        end else begin
          logic [DW-1:0] d;
          string t;
          d = exp_cpu.pop_front();
          t = cpu_tag.pop_front();
          check(cpu_rdata_o == d, t, {16'd0, cpu_rdata_o}, {16'd0, d});
        end
      end
    end
  end

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [DW-1:0] exp_d, input string req);
    exp_cpu.push_back(exp_d);
    cpu_tag.push_back(req);
    @(negedge clk);
    cpu_req_i = 1; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = d;
    @(negedge clk);
    cpu_req_i = 0;
    for (int n = 0; n < 50 && !cpu_done_o; n++) @(negedge clk);
    @(negedge clk);
    #6;
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit exp_sh, input bit exp_fl, input logic [DW-1:0] exp_fd, input string req);
    @(negedge clk);
    snp_cmd_i = cmd; snp_addr_i = a; snp_data_i = d;
    #5;
    check(snp_shared_o == exp_sh, {req, " shared"}, {31'd0, snp_shared_o}, {31'd0, exp_sh});
    check(snp_flush_o == exp_fl, {req, " flush"}, {31'd0, snp_flush_o}, {31'd0, exp_fl});
    if (exp_fl) check(snp_flush_data_o == exp_fd, {req, " flush data"}, {16'd0, snp_flush_data_o}, {16'd0, exp_fd});
    @(negedge clk);
    snp_cmd_i = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + 16'(i * 3);
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    @(negedge clk);
    check(cpu_ready_o == 1, "R1 ready", {31'd0, cpu_ready_o}, 1);
    check(bus_req_o == 0, "R1 bus_req", {31'd0, bus_req_o}, 0);
    check(cpu_done_o == 0, "R1 done", {31'd0, cpu_done_o}, 0);
    snoop(2'd1, 8'h00, 0, 0, 0, 0, "R1 empty line snoop");

    peer_share = 0;
    expect_bus(2'd1, 8'h04, 0, 0, "R2 read miss bus read");
    cpu_op(0, 8'h04, 0, mem[8'h04], "R2 read miss data");
    cpu_op(0, 8'h04, 0, mem[8'h04], "R3 read hit");
    cpu_op(1, 8'h04, 16'hAAAA, 16'hAAAA, "R4 write hit exclusive");
    snoop(2'd1, 8'h04, 0, 1, 1, 16'hAAAA, "R8 snoop read modified");

    peer_share = 1;
    expect_bus(2'd2, 8'h04, 16'hBBBB, 1, "R5 update from shared-modified");
    cpu_op(1, 8'h04, 16'hBBBB, 16'hBBBB, "R5 write hit shared");
    snoop(2'd2, 8'h04, 16'hCCCC, 1, 0, 0, "R9 snoop update");
    cpu_op(0, 8'h04, 0, 16'hCCCC, "R9 updated word readable");

    peer_share = 0;
    expect_bus(2'd2, 8'h04, 16'hDDDD, 1, "R9 shared-clean needs update");
    cpu_op(1, 8'h04, 16'hDDDD, 16'hDDDD, "R5 write hit shared-clean no sharer");
    cpu_op(1, 8'h04, 16'hEEEE, 16'hEEEE, "R4 write hit modified silent");

    peer_share = 1;
    expect_bus(2'd3, 8'h04, 16'hEEEE, 1, "R7 flush dirty victim");
    expect_bus(2'd1, 8'h14, 0, 0, "R7 read after flush");
    cpu_op(0, 8'h14, 0, mem[8'h14], "R7 miss with dirty victim");
    check(mem[8'h04] == 16'hEEEE, "R7 memory holds flushed word", {16'd0, mem[8'h04]}, 32'hEEEE);

    peer_share = 0;
    expect_bus(2'd1, 8'h24, 0, 0, "R7 clean victim dropped silently");
    cpu_op(0, 8'h24, 0, mem[8'h24], "R2 shared fill then replaced");
    snoop(2'd1, 8'h24, 0, 1, 0, 0, "R8 snoop read exclusive");
    peer_share = 1;
    expect_bus(2'd2, 8'h24, 16'h1234, 1, "R8 exclusive became shared-clean");
    cpu_op(1, 8'h24, 16'h1234, 16'h1234, "R5 write hit shared-clean");
    snoop(2'd1, 8'h24, 0, 1, 1, 16'h1234, "R8 snoop read shared-modified");
    peer_share = 0;
    expect_bus(2'd2, 8'h24, 16'h5555, 1, "R8 stays shared-modified");
    cpu_op(1, 8'h24, 16'h5555, 16'h5555, "R5 write hit ends modified");

    snoop(2'd1, 8'h34, 0, 0, 0, 0, "R10 snoop read tag mismatch");
    snoop(2'd2, 8'h34, 16'h9999, 0, 0, 0, "R10 snoop update tag mismatch");
    cpu_op(0, 8'h24, 0, 16'h5555, "R10 line unchanged");
    cpu_op(1, 8'h24, 16'h6666, 16'h6666, "R10 still modified");

    peer_share = 1;
    expect_bus(2'd1, 8'h05, 0, 0, "R6 write miss bus read");
    expect_bus(2'd2, 8'h05, 16'h7777, 1, "R6 write miss update");
    cpu_op(1, 8'h05, 16'h7777, 16'h7777, "R6 write miss shared");
    peer_share = 0;
    expect_bus(2'd2, 8'h05, 16'h7878, 1, "R6 shared-modified after write miss");
    cpu_op(1, 8'h05, 16'h7878, 16'h7878, "R6 write hit after shared miss");
    expect_bus(2'd1, 8'h06, 0, 0, "R6 private write miss read");
    cpu_op(1, 8'h06, 16'h8888, 16'h8888, "R6 write miss private");
    cpu_op(1, 8'h06, 16'h8989, 16'h8989, "R6 private write miss ends modified");

    gnt_en = 0;
    expect_bus(2'd1, 8'h07, 0, 0, "R11 read after grant");
    fork
      cpu_op(0, 8'h07, 0, mem[8'h07], "R11 delayed grant data");
      begin
        repeat (3) @(negedge clk);
        for (int k = 0; k < 5; k++) begin
          #5;
          check(bus_req_o == 1 && bus_cmd_o == 0, "R11 no command without grant",
                {29'd0, bus_req_o, bus_cmd_o}, 32'h4);
          @(negedge clk);
        end
        gnt_en = 1;
      end
    join

    repeat (3) @(negedge clk);
    check(exp_bus.size() == 0, "R11 all bus transactions seen", exp_bus.size(), 0);
    check(exp_cpu.size() == 0, "R3 all completions seen", exp_cpu.size(), 0);
    summary();
  end
endmodule